// File: doc/BRIEF.md
# Digit-Serial Adder with Word Reset

This block adds two binary words that arrive a digit at a time, least significant digit first, with J bits per digit. It is the bit-serial adder with its carry feedback loop unfolded J times. The J lanes form one ripple chain inside a cycle. A single register carries the carry from the top lane back to lane 0 for the next digit. A W-bit word therefore takes W/J valid cycles when J divides W.

When J does not divide W, a word can begin in the middle of a digit. The block follows a periodic schedule that repeats every L = lcm(W, J) bits, which is L/J digits. A phase counter gives the position of the current digit inside that period. A table built at elaboration gives, for each phase, the lanes whose carry input must be forced to zero because they hold bit 0 of a word.

The source marks the first valid digit of a stream with a sync flag, which aligns lane 0 with bit 0 of a word. After that, the stream must stay continuous in bit order. Idle cycles may appear between digits.

Top module: `digit_serial_add`

## Requirements
- R1: While reset is low, `out_valid` is 0, `sum_dig` is 0, the carry register is 0 and the phase counter is 0.
- R2: `out_valid` equals the `in_valid` of the previous cycle, so each accepted digit produces exactly one output digit one cycle later.
- R3: Bit j of an output digit is a XOR b XOR c, where a and b are bit j of the input digits and c is the carry into lane j. The carry out of lane j feeds lane j+1 in the same cycle.
- R4: The carry out of lane J-1 is stored and used as the carry into lane 0 on the next valid digit.
- R5: Stream bit k sits in lane k mod J of digit k div J, counting from the digit that carries sync, with lane 0 as the least significant bit. When k mod W is 0, that lane starts a word and its carry input is 0, whatever the stored carry is.
- R6: On each valid digit the phase advances by one modulo L/J, where L = lcm(W, J). When `in_valid` is low, the phase and the stored carry keep their values.
- R7: A valid digit with `in_sync` high is taken as phase 0, so its lane 0 is bit 0 of a word. `in_sync` has no effect while `in_valid` is low.
- R8: Each output word, rebuilt from the output stream in bit order, equals (A + B) mod 2^W of the matching input words, including when W is not a multiple of J.
- R9: `sum_dig` holds its value on cycles that follow a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The digit on `a_dig`/`b_dig` is valid this cycle |
| in_sync | input | 1 | With `in_valid`: this digit is phase 0 of the schedule |
| a_dig | input | J | Operand A digit, bit 0 least significant |
| b_dig | input | J | Operand B digit, bit 0 least significant |
| sum_dig | output | J | Registered sum digit |
| out_valid | output | 1 | `sum_dig` holds a new digit |

## Verification
On every cycle the assertions check the one-cycle valid lag and the holding of sum, carry and phase across idle cycles. They also check the phase step and wrap, the forcing of phase 0 by sync, and a zero carry into lane 0 on a sync digit. The correctness of the carry clearing at word starts in the middle of a digit, and of carries rippling across digit boundaries, can only be seen from the bench's scenarios. These include all-ones plus one and all-ones plus all-ones words, gaps in the stream, streams without sync that continue across the period wrap, and an aborted stream followed by a resync. The bench checks them against its bit-level model and against reassembled word sums.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    function automatic int gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm(input int a, input int b);
        return (a / gcd(a, b)) * b;
    endfunction

    function automatic int cnt_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dsa_phase_ctr.sv
module dsa_phase_ctr #(
    parameter int P  = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          sync,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(P - 1);

    logic [PW-1:0] ph_d, ph_q, cur;

    always_comb begin
        cur  = (adv && sync) ? '0 : ph_q;
        ph_d = ph_q;
        if (adv) begin
            ph_d = (cur == LAST) ? '0 : cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase = cur;
endmodule

// File: rtl/dsa_sched_rom.sv
module dsa_sched_rom #(
    parameter int W  = 8,
    parameter int J  = 3,
    parameter int P  = 8,
    parameter int PW = 3
) (
    input  logic [PW-1:0] phase,
    output logic [J-1:0]  mask
);
    logic [J-1:0] tbl [P];

    for (genvar gp = 0; gp < P; gp++) begin : g_phase
        for (genvar gj = 0; gj < J; gj++) begin : g_lane
            localparam int BITIX = gp * J + gj;
            assign tbl[gp][gj] = ((BITIX % W) == 0) ? 1'b1 : 1'b0;
        end
    end

    always_comb begin
        mask = '0;
        for (int p = 0; p < P; p++) begin
            if (phase == PW'(p)) mask = tbl[p];
        end
    end
endmodule

// File: rtl/dsa_carry_chain.sv
module dsa_carry_chain #(
    parameter int J = 3
) (
    input  logic [J-1:0] a,
    input  logic [J-1:0] b,
    input  logic         cin,
    input  logic [J-1:0] clr,
    output logic [J-1:0] sum,
    output logic         cout
);
    logic [J:0] c;
    assign c[0] = cin;

    for (genvar g = 0; g < J; g++) begin : g_lane
        logic ci;
        assign ci      = clr[g] ? 1'b0 : c[g];
        assign sum[g]  = a[g] ^ b[g] ^ ci;
        assign c[g+1]  = (a[g] & b[g]) | (ci & (a[g] ^ b[g]));
    end

    assign cout = c[J];
endmodule

// File: rtl/digit_serial_add.sv
module digit_serial_add #(
    parameter int W = 8,
    parameter int J = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_sync,
    input  logic [J-1:0] a_dig,
    input  logic [J-1:0] b_dig,
    output logic [J-1:0] sum_dig,
    output logic         out_valid
);
    localparam int L  = dsa_pkg::lcm(W, J);
    localparam int P  = L / J;
    localparam int PW = dsa_pkg::cnt_width(P);

    typedef struct packed {
        logic         carry;
        logic         vld;
        logic [J-1:0] sum;
    } st_t;

    st_t           st_d, st_q;
    logic          carry_q;
    logic [PW-1:0] phase_cur;
    logic [J-1:0]  clr_mask;
    logic [J-1:0]  lane_sum;
    logic          lane_cout;

    dsa_phase_ctr #(.P(P), .PW(PW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .sync  (in_sync),
        .phase (phase_cur)
    );

    dsa_sched_rom #(.W(W), .J(J), .P(P), .PW(PW)) u_sched (
        .phase (phase_cur),
        .mask  (clr_mask)
    );

    dsa_carry_chain #(.J(J)) u_chain (
        .a    (a_dig),
        .b    (b_dig),
        .cin  (carry_q),
        .clr  (clr_mask),
        .sum  (lane_sum),
        .cout (lane_cout)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sum   = lane_sum;
            st_d.carry = lane_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry_q   = st_q.carry;
    assign sum_dig   = st_q.sum;
    assign out_valid = st_q.vld;
endmodule

// File: rtl/digit_serial_add_chk.sv
module digit_serial_add_chk #(
    parameter int W  = 8,
    parameter int J  = 3,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sync,
    input logic [J-1:0]  a_dig,
    input logic [J-1:0]  b_dig,
    input logic [J-1:0]  sum_dig,
    input logic          out_valid,
    input logic          carry_q,
    input logic [PW-1:0] phase_cur
);
    localparam int P = dsa_pkg::lcm(W, J) / J;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && sum_dig == '0 && !carry_q));

    p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(carry_q));

    p_sync_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=> (sum_dig[0] == ($past(a_dig[0]) ^ $past(b_dig[0]))));

    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sync) |=>
            ((in_valid && in_sync) || int'(phase_cur) == ((int'($past(phase_cur)) + 1) % P)));

    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !$isunknown(phase_cur)) |=>
            ((in_valid && in_sync) || $stable(phase_cur)));

    p_sync_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=>
            ((in_valid && in_sync) || int'(phase_cur) == (1 % P)));

    p_sum_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_dig));
endmodule

bind digit_serial_add digit_serial_add_chk #(.W(W), .J(J), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .a_dig     (a_dig),
    .b_dig     (b_dig),
    .sum_dig   (sum_dig),
    .out_valid (out_valid),
    .carry_q   (carry_q),
    .phase_cur (phase_cur)
);

// File: tb/digit_serial_add_bench.sv
module digit_serial_add_bench;
    localparam int W   = 8;
    localparam int J   = 3;
    localparam int L   = dsa_pkg::lcm(W, J);
    localparam int WPP = L / W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_sync = 1'b0;
    logic [J-1:0] a_dig = '0;
    logic [J-1:0] b_dig = '0;
    logic [J-1:0] sum_dig;
    logic         out_valid;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    bit rx_q[$];
    logic prev_iv = 1'b0;
    logic [J-1:0] last_sum = '0;

    always #4 clk = ~clk;

    digit_serial_add #(.W(W), .J(J)) u_digit_serial_add (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .a_dig(a_dig), .b_dig(b_dig), .sum_dig(sum_dig), .out_valid(out_valid)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // cycle-by-cycle comparison with the bit-stream model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== prev_iv) begin
                errors++;
                $display("FAIL R2 out_valid got %b exp %b", out_valid, prev_iv);
            end
            if (out_valid === 1'b1) begin
                logic [J-1:0] e;
                e = '0;
                for (int j = 0; j < J; j++) begin
                    if (exp_q.size() > 0) e[j] = exp_q.pop_front();
                    rx_q.push_back(sum_dig[j]);
                end
                checks++;
                if (sum_dig !== e) begin
                    errors++;
                    $display("FAIL R3 R4 R5 digit got %b exp %b", sum_dig, e);
                end
            end else begin
                checks++;
                if (sum_dig !== last_sum) begin
                    errors++;
                    $display("FAIL R9 idle sum got %b exp %b", sum_dig, last_sum);
                end
            end
        end
        last_sum = sum_dig;
        prev_iv  = in_valid;
    end

    task automatic drive_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_sync  = 1'($urandom);   // R7: ignored while idle
            a_dig    = J'($urandom);
            b_dig    = J'($urandom);
        end
    endtask

    // mode 0 random, 1 ones+1, 2 ones+ones, 3 a + ~a
    task automatic run_stream(input int nw, input int mode, input int gap,
                              input bit sync_first, input int cut);
        bit ab[$];
        bit bb[$];
        bit sb[$];
        logic [W-1:0] sums[$];
        int nd;
        for (int w = 0; w < nw; w++) begin
            logic [W-1:0] wa, wb, ws;
            case (mode)
                1: begin wa = '1; wb = W'(1); end
                2: begin wa = '1; wb = '1; end
                3: begin wa = W'($urandom); wb = ~wa; end
                default: begin wa = W'($urandom); wb = W'($urandom); end
            endcase
            ws = wa + wb;
            sums.push_back(ws);
            for (int i = 0; i < W; i++) begin
                ab.push_back(wa[i]);
                bb.push_back(wb[i]);
                sb.push_back(ws[i]);
            end
        end
        nd = (nw * W) / J;
        if (cut > 0) nd = cut;
        rx_q.delete();
        for (int d = 0; d < nd; d++) begin
            if (gap > 0 && $urandom_range(0, 99) < gap) drive_idle($urandom_range(1, 3));
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_sync  = (d == 0) && sync_first;
            for (int j = 0; j < J; j++) begin
                a_dig[j] = ab[d*J + j];
                b_dig[j] = bb[d*J + j];
                exp_q.push_back(sb[d*J + j]);
            end
        end
        drive_idle(3);
        exp_q.delete();
        if (cut == 0) begin
            for (int w = 0; w < nw; w++) begin
                logic [W-1:0] got;
                got = '0;
                for (int i = 0; i < W; i++)
                    if (w*W + i < rx_q.size()) got[i] = rx_q[w*W + i];
                checks++;
                if (got !== sums[w]) begin
                    errors++;
                    $display("FAIL R8 word %0d got %h exp %h", w, got, sums[w]);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 reset state
        if (out_valid !== 1'b0 || sum_dig !== '0) begin
            errors++;
            $display("FAIL R1 reset got v=%b s=%b exp v=0 s=0", out_valid, sum_dig);
        end
        rst_n = 1'b1;
        drive_idle(2);
        run_stream(WPP, 1, 0, 1'b1, 0);      // R3 R4 R5 ripple, clear mid-digit
        run_stream(2*WPP, 2, 0, 1'b0, 0);    // R6 wrap without sync
        run_stream(10*WPP, 0, 30, 1'b1, 0);  // R6 R9 gaps
        run_stream(2*WPP, 3, 0, 1'b1, 0);    // R3 no carries
        run_stream(WPP, 0, 0, 1'b1, 4);      // abort mid-period
        run_stream(3*WPP, 0, 20, 1'b1, 0);   // R7 resync
        run_stream(20*WPP, 0, 0, 1'b1, 0);   // R8 bulk
        summary();
        $finish;
    end
endmodule